// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers four kinds of interrupt request and presents a single winner to a CPU core. The kinds are an edge-triggered non-maskable pin, four level-sensitive request pins, a four-bit active-low encoded priority bus, and a vector of on-chip peripheral requests. Each level pin and each peripheral has a programmable four-bit priority. The non-maskable source always sits at level 16. The encoded bus carries its own level.

Each cycle the controller finds the highest pending level and applies a fixed tie-break order. It compares the result against the core's four-bit mask and block bit, then drives a valid flag, the winning level and a source code. It also drives a suggested new mask value, but only for maskable winners. The core names the source it takes on an accept strobe.

A write-only configuration port selects the non-maskable edge polarity, sets a bypass of the block bit, and loads the per-source priorities. Asynchronous pins are synchronized before use.

Top module: `irq_arbiter_top`

## Requirements
- R1: After reset `irq_valid` is 0, the non-maskable detector looks for falling edges, and the block-bit bypass is off.
- R2: A code c on `prio_bus_n` requests level 15 minus c. Code 15 means no request, so code 0 is level 15 and code 9 is level 6.
- R3: A level pin i or peripheral j requests its programmed priority only while its input is high. Priority 0 masks the source. When the input drops, the request goes away.
- R4: A maskable request is presented only when its level is strictly greater than `cpu_mask` and `cpu_block` is 0.
- R5: Source codes are 0 for non-maskable, 1 for the encoded bus, 2+i for level pin i and 6+j for peripheral j. On equal levels the order of preference is: non-maskable, then the encoded bus, then the level pins from pin 3 down to pin 0, then the peripherals from index 0 upward.
- R6: The non-maskable source is presented at level 16 once an edge of the selected polarity has passed the synchronizer. It stays pending until an accept with `ack_src` = 0. An accept that names another source does not clear it, and a new edge in the same cycle as the clearing accept keeps it pending.
- R7: A pending non-maskable request is held off while `cpu_block` is 1, unless `cpu_sleep` is 1 or the bypass bit is set.
- R8: The detector ignores edges that reach it in the cycle of a control-register write or in any of the six cycles after that write.
- R9: `irq_mask_load` is 1 with `irq_new_mask` equal to the winning level for a maskable winner. It is 0 when the non-maskable source wins.
- R10: The register map is as follows. Address 0 holds control, with bit 0 = 1 for rising edges and bit 1 = block-bit bypass. Addresses 1 to 4 hold the priorities of level pins 0 to 3. Addresses 5 and up hold the priorities of the peripherals in index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable request pin, asynchronous |
| lvl_pins | input | 4 | Level-sensitive request pins, active high, asynchronous |
| prio_bus_n | input | 4 | Active-low encoded priority bus, asynchronous |
| periph_req | input | NUM_PERIPH | Peripheral request lines, synchronous |
| cpu_mask | input | 4 | Core interrupt mask level |
| cpu_block | input | 1 | Core block bit |
| cpu_sleep | input | 1 | Core in sleep or standby |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | 4 | Configuration write data |
| irq_ack | input | 1 | Accept strobe from the core |
| ack_src | input | SRC_W | Source code being accepted |
| irq_valid | output | 1 | A request is presented |
| irq_level | output | 5 | Level of the presented request |
| irq_src | output | SRC_W | Source code of the presented request |
| irq_mask_load | output | 1 | Core should load a new mask |
| irq_new_mask | output | 4 | Mask value to load |

## Verification
Two events can land on the same clock edge. One is a fresh non-maskable edge setting the sticky flag. The other is an accept strobe clearing that same flag. The bench raises the pin, counts two edges through the synchronizer, and drives an accept for source 0 so that it lands on the edge where the new detection registers. It then expects the request still to be presented, and expects a later lone accept to clear it. A second case is a control write followed at once by a pin edge. The bench places the edge so that it reaches the detector inside the suppression window, checks that it is lost, and then checks that an edge after the window is caught.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int          NUM_PINS  = 4;
  localparam int          LVL_W     = 5;
  localparam logic [4:0]  NMI_LEVEL = 5'd16;
  localparam int          SRC_NMI   = 0;
  localparam int          SRC_ENC   = 1;
  localparam int          SRC_PIN0  = 2;
  localparam int          SRC_PER0  = SRC_PIN0 + NUM_PINS;
  localparam int          BLIND_CYC = 6;

  typedef struct packed {
    logic bypass_block;
    logic edge_rise;
  } nmi_ctrl_t;

  function automatic logic [3:0] enc_to_level(input logic [3:0] code_n);
    return 4'hF - code_n;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q_sync <= RST_VAL;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int ADDR_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [3:0]                 wdata,
  output nmi_ctrl_t                  ctrl,
  output logic                       ctrl_wr,
  output logic [NUM_PINS-1:0][3:0]   pin_prio,
  output logic [NUM_PERIPH-1:0][3:0] per_prio
);
  assign ctrl_wr = we && (addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_wr) ctrl <= nmi_ctrl_t'(wdata[1:0]);
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic en;
    assign en = we && (addr == ADDR_W'(1 + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pin_prio[i] <= '0;
      else if (en) pin_prio[i] <= wdata;
    end
  end

  for (genvar j = 0; j < NUM_PERIPH; j++) begin : g_per
    logic en;
    assign en = we && (addr == ADDR_W'(1 + NUM_PINS + j));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  per_prio[j] <= '0;
      else if (en) per_prio[j] <= wdata;
    end
  end
endmodule

// File: rtl/irq_nmi_detect.sv
module irq_nmi_detect
  import irq_pkg::*;
#(
  parameter int BLIND = BLIND_CYC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_s,
  input  logic edge_rise,
  input  logic ctrl_wr,
  input  logic clr,
  output logic pend,
  output logic blind
);
  localparam int CNT_W = $clog2(BLIND + 1);

  logic             prev_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_d, hit;

  assign blind = ctrl_wr || (cnt_q != '0);
  assign hit   = edge_rise ? (nmi_s && !prev_q) : (!nmi_s && prev_q);

  always_comb begin
    cnt_d = cnt_q;
    if (ctrl_wr)           cnt_d = CNT_W'(BLIND);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    pend_d = pend;
    if (hit && !blind)     pend_d = 1'b1;
    else if (clr)          pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      pend   <= 1'b0;
    end else begin
      prev_q <= nmi_s;
      cnt_q  <= cnt_d;
      pend   <= pend_d;
    end
  end
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int SRC_W      = 4
) (
  input  logic [3:0]                 enc_lvl,
  input  logic [NUM_PINS-1:0]        pin_req,
  input  logic [NUM_PINS-1:0][3:0]   pin_prio,
  input  logic [NUM_PERIPH-1:0]      per_req,
  input  logic [NUM_PERIPH-1:0][3:0] per_prio,
  input  logic                       nmi_pend,
  input  logic                       nmi_ok,
  input  logic [3:0]                 cpu_mask,
  input  logic                       cpu_block,
  output logic                       valid,
  output logic [LVL_W-1:0]           level,
  output logic [SRC_W-1:0]           src,
  output logic                       mask_load
);
  logic [3:0]       best_lvl, cand;
  logic [SRC_W-1:0] best_src;

  always_comb begin
    best_lvl = enc_lvl;
    best_src = SRC_W'(SRC_ENC);
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      cand = pin_req[i] ? pin_prio[i] : 4'd0;
      if (cand > best_lvl) begin
        best_lvl = cand;
        best_src = SRC_W'(SRC_PIN0 + i);
      end
    end
    for (int j = 0; j < NUM_PERIPH; j++) begin
      cand = per_req[j] ? per_prio[j] : 4'd0;
      if (cand > best_lvl) begin
        best_lvl = cand;
        best_src = SRC_W'(SRC_PER0 + j);
      end
    end
  end

  always_comb begin
    valid     = 1'b0;
    level     = '0;
    src       = '0;
    mask_load = 1'b0;
    if (nmi_pend && nmi_ok) begin
      valid = 1'b1;
      level = NMI_LEVEL;
      src   = SRC_W'(SRC_NMI);
    end else if (best_lvl != 4'd0 && best_lvl > cpu_mask && !cpu_block) begin
      valid     = 1'b1;
      level     = {1'b0, best_lvl};
      src       = best_src;
      mask_load = 1'b1;
    end
  end
endmodule

// File: rtl/irq_arbiter_top.sv
module irq_arbiter_top
  import irq_pkg::*;
#(
  parameter  int NUM_PERIPH = 4,
  localparam int ADDR_W     = $clog2(1 + NUM_PINS + NUM_PERIPH),
  localparam int SRC_W      = $clog2(SRC_PER0 + NUM_PERIPH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  nmi_pin,
  input  logic [NUM_PINS-1:0]   lvl_pins,
  input  logic [3:0]            prio_bus_n,
  input  logic [NUM_PERIPH-1:0] periph_req,
  input  logic [3:0]            cpu_mask,
  input  logic                  cpu_block,
  input  logic                  cpu_sleep,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [3:0]            cfg_wdata,
  input  logic                  irq_ack,
  input  logic [SRC_W-1:0]      ack_src,
  output logic                  irq_valid,
  output logic [LVL_W-1:0]      irq_level,
  output logic [SRC_W-1:0]      irq_src,
  output logic                  irq_mask_load,
  output logic [3:0]            irq_new_mask
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic                       nmi_s;
  logic [NUM_PINS-1:0]        pins_s;
  logic [3:0]                 bus_s;
  nmi_ctrl_t                  ctrl;
  logic                       ctrl_wr;
  logic [NUM_PINS-1:0][3:0]   pin_prio;
  logic [NUM_PERIPH-1:0][3:0] per_prio;
  logic                       nmi_pend, nmi_blind, nmi_ok, nmi_clr;

  irq_sync #(.W(1), .RST_VAL(1'b0)) u_sync_nmi (
    .clk(clk), .rst_n(rst_sync_n), .d_async(nmi_pin), .q_sync(nmi_s));
  irq_sync #(.W(NUM_PINS), .RST_VAL('0)) u_sync_pins (
    .clk(clk), .rst_n(rst_sync_n), .d_async(lvl_pins), .q_sync(pins_s));
  irq_sync #(.W(4), .RST_VAL(4'hF)) u_sync_bus (
    .clk(clk), .rst_n(rst_sync_n), .d_async(prio_bus_n), .q_sync(bus_s));

  irq_cfg_regs #(.NUM_PERIPH(NUM_PERIPH), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .ctrl(ctrl), .ctrl_wr(ctrl_wr),
    .pin_prio(pin_prio), .per_prio(per_prio));

  assign nmi_clr = irq_ack && (ack_src == SRC_W'(SRC_NMI));
  assign nmi_ok  = !cpu_block || cpu_sleep || ctrl.bypass_block;

  irq_nmi_detect #(.BLIND(BLIND_CYC)) u_nmi (
    .clk(clk), .rst_n(rst_sync_n), .nmi_s(nmi_s), .edge_rise(ctrl.edge_rise),
    .ctrl_wr(ctrl_wr), .clr(nmi_clr), .pend(nmi_pend), .blind(nmi_blind));

  irq_prio_select #(.NUM_PERIPH(NUM_PERIPH), .SRC_W(SRC_W)) u_sel (
    .enc_lvl(enc_to_level(bus_s)), .pin_req(pins_s), .pin_prio(pin_prio),
    .per_req(periph_req), .per_prio(per_prio), .nmi_pend(nmi_pend),
    .nmi_ok(nmi_ok), .cpu_mask(cpu_mask), .cpu_block(cpu_block),
    .valid(irq_valid), .level(irq_level), .src(irq_src),
    .mask_load(irq_mask_load));

  assign irq_new_mask = irq_mask_load ? irq_level[3:0] : 4'd0;
endmodule

// File: rtl/irq_checker.sv
module irq_checker #(
  parameter int SRC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_valid,
  input logic [4:0]       irq_level,
  input logic [SRC_W-1:0] irq_src,
  input logic             irq_mask_load,
  input logic [3:0]       cpu_mask,
  input logic             cpu_block,
  input logic             irq_ack,
  input logic [SRC_W-1:0] ack_src,
  input logic             nmi_pend,
  input logic             nmi_blind
);
  assert_nmi_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_src == '0) |-> irq_level == 5'd16);

  assert_nmi_no_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_src == '0) |-> !irq_mask_load);

  assert_above_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_src != '0) |-> (irq_level[3:0] > cpu_mask && !cpu_block));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !(irq_ack && ack_src == '0)) |=> nmi_pend);

  assert_blind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_pend) |-> !$past(nmi_blind));

  assert_nonzero_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_level != 5'd0);
endmodule

bind irq_arbiter_top irq_checker #(.SRC_W(SRC_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_level(irq_level),
  .irq_src(irq_src), .irq_mask_load(irq_mask_load), .cpu_mask(cpu_mask),
  .cpu_block(cpu_block), .irq_ack(irq_ack), .ack_src(ack_src),
  .nmi_pend(nmi_pend), .nmi_blind(nmi_blind));

// File: tb/test_irq_arbiter_top.sv
module test_irq_arbiter_top;
  localparam int NP     = 4;
  localparam int ADDR_W = $clog2(5 + NP);
  localparam int SRC_W  = $clog2(6 + NP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_pin = 1'b1;
  logic [3:0] lvl_pins = '0;
  logic [3:0] prio_bus_n = 4'hF;
  logic [NP-1:0] periph_req = '0;
  logic [3:0] cpu_mask = '0;
  logic cpu_block = 1'b0, cpu_sleep = 1'b0;
  logic cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [3:0] cfg_wdata = '0;
  logic irq_ack = 1'b0;
  logic [SRC_W-1:0] ack_src = '0;
  logic irq_valid, irq_mask_load;
  logic [4:0] irq_level;
  logic [SRC_W-1:0] irq_src;
  logic [3:0] irq_new_mask;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [3:0] m_pin_p [4];
  logic [3:0] m_per_p [NP];

  always #4 clk = ~clk;

  irq_arbiter_top #(.NUM_PERIPH(NP)) i_irq_arbiter_top (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .lvl_pins(lvl_pins),
    .prio_bus_n(prio_bus_n), .periph_req(periph_req), .cpu_mask(cpu_mask),
    .cpu_block(cpu_block), .cpu_sleep(cpu_sleep), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .irq_ack(irq_ack),
    .ack_src(ack_src), .irq_valid(irq_valid), .irq_level(irq_level),
    .irq_src(irq_src), .irq_mask_load(irq_mask_load),
    .irq_new_mask(irq_new_mask));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input bit v, input int lvl, input int src);
    check({req, " valid"}, int'(irq_valid), int'(v));
    if (v) begin
      check({req, " level"}, int'(irq_level), lvl);
      check({req, " src"}, int'(irq_src), src);
      check({req, " mask_load"}, int'(irq_mask_load), (src != 0) ? 1 : 0);
      if (src != 0) check({req, " new_mask"}, int'(irq_new_mask), lvl);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = ADDR_W'(a); cfg_wdata = 4'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a >= 1 && a <= 4) m_pin_p[a-1] = 4'(d);
    else if (a >= 5 && a < 5 + NP) m_per_p[a-5] = 4'(d);
  endtask

  task automatic ack(input int s);
    irq_ack = 1'b1; ack_src = SRC_W'(s);
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  function automatic void model(output bit v, output int lvl, output int src);
    int best, bsrc;
    best = 15 - int'(prio_bus_n); bsrc = 1;
    for (int i = 3; i >= 0; i--)
      if (lvl_pins[i] && int'(m_pin_p[i]) > best) begin best = int'(m_pin_p[i]); bsrc = 2 + i; end
    for (int j = 0; j < NP; j++)
      if (periph_req[j] && int'(m_per_p[j]) > best) begin best = int'(m_per_p[j]); bsrc = 6 + j; end
    v = (best != 0) && (best > int'(cpu_mask)) && !cpu_block;
    lvl = best; src = bsrc;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit v; int lvl, src;
    int seed;
    seed = int'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) m_pin_p[i] = '0;
    for (int j = 0; j < NP; j++) m_per_p[j] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(5);
    expect_out("R1 reset", 0, 0, 0);

    // R1 default falling polarity; R5 non-maskable beats level 15; R6, R9
    prio_bus_n = 4'h0; nmi_pin = 1'b0;
    cyc(4);
    expect_out("R6 falling edge", 1, 16, 0);
    ack(1);
    expect_out("R6 other ack keeps", 1, 16, 0);
    ack(0);
    expect_out("R2 code0 level15 R9", 1, 15, 1);
    prio_bus_n = 4'hF; nmi_pin = 1'b1;
    cyc(4);
    expect_out("R2 code15 none", 0, 0, 0);

    // R7 block handling, R10 control bits
    wr(0, 1); cyc(10);
    cpu_block = 1'b1;
    nmi_pin = 1'b0; cyc(4);
    nmi_pin = 1'b1; cyc(4);
    expect_out("R7 blocked", 0, 0, 0);
    cpu_sleep = 1'b1; cyc(1);
    expect_out("R7 sleep overrides", 1, 16, 0);
    cpu_sleep = 1'b0; cyc(1);
    expect_out("R7 blocked again", 0, 0, 0);
    wr(0, 3); cyc(1);
    expect_out("R7 R10 bypass bit", 1, 16, 0);
    wr(0, 1); cpu_block = 1'b0; cyc(1);
    expect_out("R6 pending kept", 1, 16, 0);
    ack(0);
    expect_out("R6 cleared", 0, 0, 0);

    // R8 blind window
    nmi_pin = 1'b0; cyc(4);
    wr(0, 1);
    nmi_pin = 1'b1;
    cyc(10);
    expect_out("R8 edge in window lost", 0, 0, 0);
    nmi_pin = 1'b0; cyc(4);
    nmi_pin = 1'b1; cyc(4);
    expect_out("R8 edge after window", 1, 16, 0);
    // same-cycle new edge and clearing accept
    nmi_pin = 1'b0; cyc(4);
    nmi_pin = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    irq_ack = 1'b1; ack_src = '0;
    @(negedge clk);
    irq_ack = 1'b0;
    expect_out("R6 set beats clear", 1, 16, 0);
    ack(0);
    expect_out("R6 lone ack clears", 0, 0, 0);

    // R2 / R4 mask boundary
    prio_bus_n = 4'd9; cpu_mask = 4'd5; cyc(3);
    expect_out("R2 code9 level6", 1, 6, 1);
    cpu_mask = 4'd6; cyc(1);
    expect_out("R4 equal mask blocks", 0, 0, 0);
    cpu_mask = 4'd0; cpu_block = 1'b1; cyc(1);
    expect_out("R4 block bit", 0, 0, 0);
    cpu_block = 1'b0; prio_bus_n = 4'hF;

    // R3 masked priority and level drop; R10 map
    wr(2, 0); lvl_pins = 4'b0010; cyc(3);
    expect_out("R3 priority0 masked", 0, 0, 0);
    wr(3, 4); lvl_pins = 4'b0100; cyc(3);
    expect_out("R3 R10 pin2 prio", 1, 4, 4);
    lvl_pins = 4'b0000; cyc(3);
    expect_out("R3 pin drop", 0, 0, 0);

    // R5 ties at level 7
    wr(4, 7); wr(5, 7); wr(1, 7); wr(6, 7);
    prio_bus_n = 4'd8; lvl_pins = 4'b1001; periph_req = 4'b0011; cyc(3);
    expect_out("R5 bus first", 1, 7, 1);
    prio_bus_n = 4'hF; cyc(3);
    expect_out("R5 pin3 over pin0", 1, 7, 5);
    lvl_pins = 4'b0000; cyc(3);
    expect_out("R5 periph0 over periph1", 1, 7, 6);
    periph_req = 4'b0010; cyc(1);
    expect_out("R5 R10 periph1", 1, 7, 7);

    // random phase against the model
    for (int it = 0; it < 300; it++) begin
      if ($urandom % 3 == 0) wr(1 + int'($urandom % (4 + NP)), int'($urandom % 16));
      prio_bus_n = 4'($urandom); lvl_pins = 4'($urandom);
      periph_req = NP'($urandom); cpu_mask = 4'($urandom);
      cpu_block = ($urandom % 4 == 0);
      cyc(3);
      model(v, lvl, src);
      expect_out("R2 R3 R4 R5 random", v, lvl, src);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule